// File: doc/BRIEF.md
# Thermal threshold interrupt controller

This block watches the 8-bit temperature code delivered by an on-chip sensor and turns threshold crossings into a single interrupt. Each of up to four levels has a rising threshold and a falling (hysteresis) threshold. When the code reaches a rising threshold, that level's rising status bit is set. After a rising event, the level is armed. If the code then drops to or below that level's falling threshold, the falling status bit is set. Each status bit is gated by an enable bit. The OR of the enabled pending bits drives `irq_o`. Software clears status bits by writing ones.

An emulation register lets software substitute a programmed code for the live sensor reading. The substitute code is used both for the readback and for every threshold comparison. Configuration and status go through a simple register port: an address, a write strobe, write data and combinational read data. Writes take effect on the rising clock edge.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset, the registers hold these values: control 0x2, rising thresholds 0xFFFFFFFF, falling thresholds 0, enables 0, status 0, emulation 0. `irq_o` is low.
- R2: The current-code register (offset 0x04) returns the live sensor code in bits [7:0]. When emulation bit 0 is set, it returns the emulated code instead. Clearing bit 0 restores the live code.
- R3: Rising thresholds are held at offset 0x08, with level i in bits [8i+7:8i]. On a clock edge where the code is greater than or equal to a level's byte, that level's rising status bit (status bit 4i) becomes 1.
- R4: Falling thresholds are held at offset 0x0C in the same byte layout. An armed level sets its falling status bit (status bit 16+4i) on an edge where the code is less than or equal to its nonzero falling byte. A falling byte of zero never sets that bit.
- R5: A level is armed by its rising condition and disarmed when its falling bit sets. A level that has never seen a rising condition since reset does not set its falling bit.
- R6: Writing to the clear register (offset 0x18) clears each status bit whose position holds a 1 in the write data. In the same edge, a still-true set condition wins over the clear. Status bits otherwise stay set.
- R7: The enable register (offset 0x10) keeps only bits 4i (rising) and 16+4i (falling). `irq_o` is high exactly when the core is on and some status bit and its enable bit are both 1. The status image reads back at offset 0x14.
- R8: Control bits [1:0] at offset 0x00 turn the core on with value 3. Any other value holds `irq_o` low, whatever status is pending.
- R9: The emulation register (offset 0x1C) has its enable in bit 0, the emulated code in [15:8] and a settle time in [31:16]. It reads back in full, for example 0x57F04801. The emulated code drives the threshold comparisons.
- R10: Threshold, enable and emulation registers read back at their offsets. Unmapped offsets and the clear register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sens_code_i | input | 8 | Live sensor temperature code |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt, high while any enabled status bit is pending and the core is on |

## Verification
A write-one-to-clear and a fresh set condition for the same status bit can land on one clock edge. The bench provokes this by holding the code above levels 0 to 2 and writing their rising clear bits. The per-cycle model gives the set priority, so it expects the status to read 0x111 on the following cycle. It also expects the interrupt to stay high. A second overlap comes from changing the emulation enable and the code source while comparisons run. This is judged by checking that the status changes one edge after the write, not on the write edge itself.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
  localparam int CODE_W    = 8;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int MAX_LVL   = 4;
  localparam int LVL_STEP  = 4;
  localparam int RISE_BASE = 0;
  localparam int FALL_BASE = 16;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TEMP  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_INTEN = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_EMU   = 8'h1C;

  localparam logic [1:0] CORE_ON  = 2'b11;
  localparam logic [1:0] CORE_OFF = 2'b10;

  function automatic logic [REG_W-1:0] lvl_mask(int levels);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < levels; i++) begin
      m[RISE_BASE + LVL_STEP*i] = 1'b1;
      m[FALL_BASE + LVL_STEP*i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/thermal_cfg_regs.sv
module thermal_cfg_regs
  import thermal_irq_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [1:0]        ctrl_o,
  output logic [REG_W-1:0]  rise_thr_o,
  output logic [REG_W-1:0]  fall_thr_o,
  output logic [REG_W-1:0]  inten_o,
  output logic [REG_W-1:0]  emu_o
);
  localparam logic [REG_W-1:0] EN_MASK = lvl_mask(LEVELS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= CORE_OFF;
      rise_thr_o <= '1;
      fall_thr_o <= '0;
      inten_o    <= '0;
      emu_o      <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CTRL:  ctrl_o     <= wdata_i[1:0];
        OFS_RISE:  rise_thr_o <= wdata_i;
        OFS_FALL:  fall_thr_o <= wdata_i;
        OFS_INTEN: inten_o    <= wdata_i & EN_MASK;
        OFS_EMU:   emu_o      <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/thermal_level_cell.sv
module thermal_level_cell
  import thermal_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] rise_thr_i,
  input  logic [CODE_W-1:0] fall_thr_i,
  input  logic              clr_rise_i,
  input  logic              clr_fall_i,
  output logic              rise_st_o,
  output logic              fall_st_o,
  output logic              armed_o
);
  logic rise_hit, fall_hit;

  assign rise_hit = code_i >= rise_thr_i;
  // zero falling byte disables the level's falling detection
  assign fall_hit = armed_o && (fall_thr_i != '0) && (code_i <= fall_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_st_o <= 1'b0;
      fall_st_o <= 1'b0;
      armed_o   <= 1'b0;
    end else begin
      // set condition outranks a same-edge clear
      rise_st_o <= (rise_st_o && !clr_rise_i) || rise_hit;
      fall_st_o <= (fall_st_o && !clr_fall_i) || fall_hit;
      if (rise_hit)      armed_o <= 1'b1;
      else if (fall_hit) armed_o <= 1'b0;
    end
  end
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
  import thermal_irq_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] sens_code_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  localparam logic [REG_W-1:0] EN_MASK = lvl_mask(LEVELS);

  logic [1:0]        ctrl_q;
  logic [REG_W-1:0]  rise_thr, fall_thr, inten_q, emu_q;
  logic [CODE_W-1:0] eff_code;
  logic [LEVELS-1:0] rise_st, fall_st, armed;
  logic [REG_W-1:0]  stat_img, clr_vec;
  logic              core_on;

  thermal_cfg_regs #(.LEVELS(LEVELS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .ctrl_o     (ctrl_q),
    .rise_thr_o (rise_thr),
    .fall_thr_o (fall_thr),
    .inten_o    (inten_q),
    .emu_o      (emu_q)
  );

  assign eff_code = emu_q[0] ? emu_q[15:8] : sens_code_i;
  assign core_on  = (ctrl_q == CORE_ON);
  assign clr_vec  = (bus_we_i && bus_addr_i == OFS_CLR) ? (bus_wdata_i & EN_MASK) : '0;

  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    thermal_level_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (eff_code),
      .rise_thr_i (rise_thr[CODE_W*g +: CODE_W]),
      .fall_thr_i (fall_thr[CODE_W*g +: CODE_W]),
      .clr_rise_i (clr_vec[RISE_BASE + LVL_STEP*g]),
      .clr_fall_i (clr_vec[FALL_BASE + LVL_STEP*g]),
      .rise_st_o  (rise_st[g]),
      .fall_st_o  (fall_st[g]),
      .armed_o    (armed[g])
    );
  end

  always_comb begin
    stat_img = '0;
    for (int i = 0; i < LEVELS; i++) begin
      stat_img[RISE_BASE + LVL_STEP*i] = rise_st[i];
      stat_img[FALL_BASE + LVL_STEP*i] = fall_st[i];
    end
  end

  assign irq_o = core_on && |(stat_img & inten_q);

  always_comb begin
    case (bus_addr_i)
      OFS_CTRL:  bus_rdata_o = {{(REG_W-2){1'b0}}, ctrl_q};
      OFS_TEMP:  bus_rdata_o = {{(REG_W-CODE_W){1'b0}}, eff_code};
      OFS_RISE:  bus_rdata_o = rise_thr;
      OFS_FALL:  bus_rdata_o = fall_thr;
      OFS_INTEN: bus_rdata_o = inten_q;
      OFS_STAT:  bus_rdata_o = stat_img;
      OFS_EMU:   bus_rdata_o = emu_q;
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/thermal_irq_chk.sv
module thermal_irq_chk
  import thermal_irq_pkg::*;
#(
  parameter int LEVELS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              core_on,
  input logic [REG_W-1:0]  stat,
  input logic [REG_W-1:0]  clr_vec,
  input logic [LEVELS-1:0] fall_st,
  input logic [LEVELS-1:0] armed,
  input logic [REG_W-1:0]  fall_thr
);
  // R8
  core_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_on |-> !irq_o);

  // R7
  irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat != '0));

  // R6
  sticky_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(stat) & ~$past(clr_vec) & ~stat) == '0));

  // R5
  fall_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((fall_st & ~$past(fall_st) & ~$past(armed)) == '0));

  for (genvar g = 0; g < LEVELS; g++) begin : g_fz
    // R4
    fall_zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_thr[CODE_W*g +: CODE_W] == '0 && !fall_st[g]) |=> !fall_st[g]);
  end
endmodule

bind thermal_irq_ctrl thermal_irq_chk #(.LEVELS(LEVELS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .core_on  (core_on),
  .stat     (stat_img),
  .clr_vec  (clr_vec),
  .fall_st  (fall_st),
  .armed    (armed),
  .fall_thr (fall_thr)
);

// File: tb/thermal_irq_ctrl_test.sv
module thermal_irq_ctrl_test;
  import thermal_irq_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sens = 8'h00;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  thermal_irq_ctrl uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sens_code_i (sens),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // behavioural reference
  logic [1:0]  m_ctrl;
  logic [7:0]  m_rise [4];
  logic [7:0]  m_fall [4];
  logic [31:0] m_en, m_emu;
  bit          m_rst [4];
  bit          m_fst [4];
  bit          m_arm [4];

  function automatic logic [7:0] m_code();
    return m_emu[0] ? m_emu[15:8] : sens;
  endfunction

  function automatic logic [31:0] m_stat();
    logic [31:0] s = '0;
    for (int i = 0; i < 4; i++) begin
      s[4*i]      = m_rst[i];
      s[16 + 4*i] = m_fst[i];
    end
    return s;
  endfunction

  function automatic logic m_irq();
    return (m_ctrl == 2'b11) && ((m_stat() & m_en) != 0);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00: return {30'b0, m_ctrl};
      8'h04: return {24'b0, m_code()};
      8'h08: return {m_rise[3], m_rise[2], m_rise[1], m_rise[0]};
      8'h0C: return {m_fall[3], m_fall[2], m_fall[1], m_fall[0]};
      8'h10: return m_en;
      8'h14: return m_stat();
      8'h1C: return m_emu;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] a);
    case (a)
      8'h00: return "R8";
      8'h04: return "R2";
      8'h14: return "R3";
      8'h1C: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl = 2'b10; m_en = 0; m_emu = 0;
      for (int i = 0; i < 4; i++) begin
        m_rise[i] = 8'hFF; m_fall[i] = 8'h00;
        m_rst[i] = 0; m_fst[i] = 0; m_arm[i] = 0;
      end
    end else begin
      int c;
      bit rc, fc, cr, cf;
      c = m_code();
      for (int i = 0; i < 4; i++) begin
        rc = c >= m_rise[i];
        fc = m_arm[i] && m_fall[i] != 0 && c <= m_fall[i];
        cr = we && addr == 8'h18 && wdata[4*i];
        cf = we && addr == 8'h18 && wdata[16 + 4*i];
        m_rst[i] = (m_rst[i] && !cr) || rc;
        m_fst[i] = (m_fst[i] && !cf) || fc;
        if (rc) m_arm[i] = 1;
        else if (fc) m_arm[i] = 0;
      end
      if (we) begin
        case (addr)
          8'h00: m_ctrl = wdata[1:0];
          8'h08: for (int i = 0; i < 4; i++) m_rise[i] = wdata[8*i +: 8];
          8'h0C: for (int i = 0; i < 4; i++) m_fall[i] = wdata[8*i +: 8];
          8'h10: m_en = wdata & 32'h1111_1111;
          8'h1C: m_emu = wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one edge pass, compare at the next negedge
  task automatic step(logic [7:0] a, logic w, logic [31:0] d);
    addr = a; we = w; wdata = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we = 1'b0;
    check("R7", {31'b0, irq}, {31'b0, m_irq()});
    check(req_of(a), rdata, m_read(a));
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(a, 1'b1, d);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(8'h14, 1'b0, 32'h0);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic irq_is(logic exp, string req);
    #1;
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(8'h00, 32'h2, "R1");
    rd(8'h08, 32'hFFFF_FFFF, "R1");
    rd(8'h0C, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h14, 32'h0, "R1");
    rd(8'h1C, 32'h0, "R1");
    irq_is(1'b0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;

    wr(8'h00, 32'h3);
    wr(8'h08, 32'h5040_3020);
    wr(8'h0C, 32'h0038_2818);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h1111_1111, "R7");
    rd(8'h08, 32'h5040_3020, "R10");
    rd(8'h18, 32'h0, "R10");

    sens = 8'h10; idle(2);
    rd(8'h14, 32'h0, "R3");
    sens = 8'h35; idle(1);
    rd(8'h14, 32'h0000_0011, "R3");
    irq_is(1'b1, "R7");
    sens = 8'h10; idle(1);
    rd(8'h14, 32'h0011_0011, "R4");

    wr(8'h18, 32'h0011_0011);
    rd(8'h14, 32'h0, "R6");
    irq_is(1'b0, "R7");

    // clear and set in the same edge: set wins
    sens = 8'h45; idle(1);
    rd(8'h14, 32'h0000_0111, "R3");
    wr(8'h18, 32'h0000_0111);
    rd(8'h14, 32'h0000_0111, "R6");
    irq_is(1'b1, "R6");

    sens = 8'h55; idle(1);
    rd(8'h14, 32'h0000_1111, "R3");
    sens = 8'h00; idle(1);
    rd(8'h14, 32'h0111_1111, "R4");
    idle(2);
    rd(8'h14, 32'h0111_1111, "R4");

    wr(8'h00, 32'h2);
    irq_is(1'b0, "R8");
    wr(8'h00, 32'h1);
    irq_is(1'b0, "R8");
    wr(8'h00, 32'h3);
    irq_is(1'b1, "R8");

    wr(8'h10, 32'h0);
    irq_is(1'b0, "R7");
    wr(8'h10, 32'h0001_0000);
    irq_is(1'b1, "R7");
    wr(8'h10, 32'h1111_1111);

    wr(8'h18, 32'h1111_1111);
    rd(8'h14, 32'h0, "R6");
    irq_is(1'b0, "R6");

    // emulation overrides the sensor
    wr(8'h1C, 32'h57F0_4801);
    rd(8'h04, 32'h48, "R2");
    rd(8'h1C, 32'h57F0_4801, "R9");
    idle(1);
    rd(8'h14, 32'h0000_0111, "R9");
    wr(8'h1C, 32'h57F0_4800);
    rd(8'h04, 32'h00, "R2");
    idle(1);
    rd(8'h14, 32'h0111_0111, "R4");

    // falling threshold without a prior rising event
    rst_ni = 1'b0;
    @(negedge clk_i);
    rd(8'h14, 32'h0, "R1");
    rst_ni = 1'b1;
    wr(8'h0C, 32'h0000_0018);
    wr(8'h00, 32'h3);
    wr(8'h10, 32'h1111_1111);
    sens = 8'h05; idle(3);
    rd(8'h14, 32'h0, "R5");
    irq_is(1'b0, "R5");
    rd(8'h04, 32'h05, "R2");

    summary();
  end
endmodule